// File: doc/BRIEF.md
# Configurable Edge Interrupt Detector

This block turns external pin activity into interrupt requests. Each channel watches one pin and keeps two configuration bits. The first bit picks the active polarity for one-sided detection. The second bit switches the channel between one-sided detection and detection of both edges. The pin first passes through a two-stage synchronizer. A qualifying transition then sets a sticky request flag. The same transition also produces a single-cycle wakeup pulse, which a power controller can use to leave a low-power retention state.

Software reads the flag with a test-and-clear poll. While the poll strobe is high, the skip output reports whether the flag is set. If it is set, the flag clears at the clock edge that ends the poll. A configuration write blocks detection for one cycle, so rewriting the bits cannot turn a stale comparison into a request. The number of channels is a parameter, and the default is two identical channels.

Top module: `edge_irq_unit`

## Requirements
- R1: While `rst` is high and after it falls, every `req_o`, `wake_o` and `skip_o` bit is 0, and each channel's configuration is polarity 0 and one-sided mode (`both` = 0).
- R2: A qualifying level change on `pin_i` that is first captured at clock edge k makes `req_o` rise after edge k+2 and not earlier.
- R3: With `rise` = 0 and `both` = 0, only a high-to-low transition of the pin sets the flag. A low-to-high transition leaves `req_o` at 0.
- R4: With `rise` = 1 and `both` = 0, only a low-to-high transition sets the flag. A high-to-low transition leaves `req_o` at 0.
- R5: With `both` = 1, either transition sets the flag, whatever the `rise` bit holds.
- R6: Once set, the flag stays at 1 until a poll clears it, even when the pin makes no further transitions.
- R7: While `poll_i` is high, `skip_o` equals the current flag. A poll that sees the flag set clears it at that clock edge.
- R8: If a qualifying edge is detected in the same cycle as a clearing poll, the flag stays at 1.
- R9: A configuration write captured at edge w blocks any detection that would set the flag at edge w+1. This holds even when the written values equal the old ones.
- R10: `wake_o` is high for exactly the one cycle after each qualifying edge is detected, in the same cycle in which the flag first reads 1. It is 0 while the flag is merely held.
- R11: Channels are independent. Pin activity, configuration or polls on one channel never change another channel's flag or wakeup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | N_CH | Asynchronous external interrupt pins |
| cfg_we_i | input | N_CH | Per-channel configuration write strobe |
| cfg_rise_i | input | N_CH | Polarity to write (0 falling, 1 rising) |
| cfg_both_i | input | N_CH | Mode to write (0 one-sided, 1 both edges) |
| poll_i | input | N_CH | Test-and-clear poll strobe |
| skip_o | output | N_CH | Poll result: flag was set |
| req_o | output | N_CH | Sticky interrupt request flags |
| wake_o | output | N_CH | One-cycle wakeup pulse per detected edge |

## Verification
The assertions check several rules on every cycle:
- a detection always sets the flag on the next edge;
- a held flag survives until a poll;
- a lone poll clears the flag;
- the wakeup pulse matches the detection cycle for cycle;
- one-sided modes only ever report the chosen direction;
- nothing is detected in the cycle after a configuration write.

Only the bench scenarios can show the rest. These are the exact three-edge latency from the pin, the full polarity and mode matrix driven from real pin waveforms, a detection colliding with a clearing poll, and the isolation between channels.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

    typedef struct packed {
        logic rise;
        logic both;
    } edge_cfg_t;

    localparam edge_cfg_t CFG_RESET = '{rise: 1'b0, both: 1'b0};

    function automatic logic edge_qualifies(edge_cfg_t c, logic now_lvl, logic old_lvl);
        logic went_up;
        logic went_down;
        went_up   = now_lvl & ~old_lvl;
        went_down = ~now_lvl & old_lvl;
        if (c.both)
            return went_up | went_down;
        else if (c.rise)
            return went_up;
        else
            return went_down;
    endfunction

endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic lvl_o,
    output logic prev_o
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain_q;
    logic         prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= pin_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[TOP-1:0], pin_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[TOP];
    end

    assign lvl_o  = chain_q[TOP];
    assign prev_o = prev_q;

    // R2: the comparison stage is the synchronized level one cycle late
    p_prev_tracks_r2: assert property (@(posedge clk) disable iff (rst)
        prev_o == $past(lvl_o));

endmodule

// File: rtl/edge_irq_detect.sv
module edge_irq_detect
    import edge_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      lvl_i,
    input  logic      prev_i,
    input  logic      cfg_we_i,
    input  edge_cfg_t cfg_i,
    output logic      hit_o
);
    edge_cfg_t cfg_q;
    logic      mute_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_RESET;
            mute_q <= 1'b0;
        end else begin
            mute_q <= cfg_we_i;
            if (cfg_we_i) cfg_q <= cfg_i;
        end
    end

    assign hit_o = ~mute_q & edge_qualifies(cfg_q, lvl_i, prev_i);

    p_write_mutes_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_we_i |=> !hit_o);

    p_fall_only_r3: assert property (@(posedge clk) disable iff (rst)
        (hit_o && !cfg_q.both && !cfg_q.rise) |-> (prev_i && !lvl_i));

    p_rise_only_r4: assert property (@(posedge clk) disable iff (rst)
        (hit_o && !cfg_q.both && cfg_q.rise) |-> (!prev_i && lvl_i));

    // R5: any reported edge in both-edge mode is a real level change
    p_both_change_r5: assert property (@(posedge clk) disable iff (rst)
        (hit_o && cfg_q.both) |-> (prev_i != lvl_i));

endmodule

// File: rtl/edge_irq_flag.sv
module edge_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic hit_i,
    input  logic poll_i,
    output logic req_o,
    output logic skip_o,
    output logic wake_o
);
    logic flag_q;
    logic wake_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            wake_q <= hit_i;
            if (hit_i)       flag_q <= 1'b1;
            else if (poll_i) flag_q <= 1'b0;
        end
    end

    assign req_o  = flag_q;
    assign skip_o = poll_i & flag_q;
    assign wake_o = wake_q;

    p_hit_sets_r8: assert property (@(posedge clk) disable iff (rst)
        hit_i |=> req_o);

    p_poll_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (poll_i && req_o && !hit_i) |=> !req_o);

    p_flag_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (req_o && !poll_i) |=> req_o);

    p_wake_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        hit_i |=> wake_o);

    p_wake_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !hit_i |=> !wake_o);

endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit
    import edge_irq_pkg::*;
#(
    parameter int N_CH      = 2,
    parameter int SYNC_DEPTH = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] pin_i,
    input  logic [N_CH-1:0] cfg_we_i,
    input  logic [N_CH-1:0] cfg_rise_i,
    input  logic [N_CH-1:0] cfg_both_i,
    input  logic [N_CH-1:0] poll_i,
    output logic [N_CH-1:0] skip_o,
    output logic [N_CH-1:0] req_o,
    output logic [N_CH-1:0] wake_o
);
    generate
        for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
            logic      lvl;
            logic      prev;
            logic      hit;
            edge_cfg_t wr_cfg;

            assign wr_cfg = '{rise: cfg_rise_i[ch], both: cfg_both_i[ch]};

            edge_irq_sync #(.STAGES(SYNC_DEPTH)) u_sync (
                .clk    (clk),
                .rst    (rst),
                .pin_i  (pin_i[ch]),
                .lvl_o  (lvl),
                .prev_o (prev)
            );

            edge_irq_detect u_det (
                .clk      (clk),
                .rst      (rst),
                .lvl_i    (lvl),
                .prev_i   (prev),
                .cfg_we_i (cfg_we_i[ch]),
                .cfg_i    (wr_cfg),
                .hit_o    (hit)
            );

            edge_irq_flag u_flag (
                .clk    (clk),
                .rst    (rst),
                .hit_i  (hit),
                .poll_i (poll_i[ch]),
                .req_o  (req_o[ch]),
                .skip_o (skip_o[ch]),
                .wake_o (wake_o[ch])
            );
        end
    endgenerate

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (req_o == '0 && wake_o == '0));

endmodule

// File: tb/edge_irq_unit_tb.sv
module edge_irq_unit_tb;
    localparam int N = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] pin = '0, we = '0, rise = '0, both = '0, poll = '0;
    logic [N-1:0] skip, req, wake;
    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    edge_irq_unit #(.N_CH(N)) u_dut (
        .clk(clk), .rst(rst), .pin_i(pin), .cfg_we_i(we), .cfg_rise_i(rise),
        .cfg_both_i(both), .poll_i(poll), .skip_o(skip), .req_o(req), .wake_o(wake)
    );

    // {rise, both, from, to, expected flag}
    localparam logic [4:0] VEC [8] = '{
        5'b00_10_1, 5'b00_01_0, 5'b10_01_1, 5'b10_10_0,
        5'b01_01_1, 5'b01_10_1, 5'b11_01_1, 5'b11_10_1
    };

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic check(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic write_cfg(int ch, logic r, logic b);
        rise[ch] = r; both[ch] = b; we[ch] = 1'b1;
        tick();
        we[ch] = 1'b0;
        tick();
    endtask

    task automatic clear(int ch);
        poll[ch] = 1'b1;
        tick();
        poll[ch] = 1'b0;
    endtask

    initial begin : watchdog
        #200000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        check("R1 req during reset", req[0] | req[1], 1'b0);
        check("R1 wake during reset", wake[0] | wake[1], 1'b0);
        rst = 1'b0;
        tick();
        check("R1 req after reset", req[0] | req[1], 1'b0);
        // default is falling one-sided: a rise must not set the flag
        pin[0] = 1'b1; tick(5);
        check("R1 default ignores rise", req[0], 1'b0);
        pin[0] = 1'b0; tick(5);
        check("R1 default sees fall", req[0], 1'b1);
        clear(0);

        // vector table: R3 R4 R5 plus R11 isolation
        for (int v = 0; v < 8; v++) begin
            write_cfg(0, VEC[v][4], VEC[v][3]);
            pin[0] = VEC[v][2]; tick(5);
            clear(0); tick();
            pin[0] = VEC[v][1]; tick(5);
            check(VEC[v][3] ? "R5 both mode" : (VEC[v][4] ? "R4 rise mode" : "R3 fall mode"),
                  req[0], VEC[v][0]);
            check("R11 other channel untouched", req[1], 1'b0);
            clear(0); tick();
        end

        // R2 latency and R10 wake pulse: rising mode
        write_cfg(0, 1'b1, 1'b0);
        pin[0] = 1'b0; tick(5); clear(0); tick();
        pin[0] = 1'b1;
        tick(); check("R2 no flag after k", req[0], 1'b0);
        tick(); check("R2 no flag after k+1", req[0], 1'b0);
        check("R10 no early wake", wake[0], 1'b0);
        tick(); check("R2 flag after k+2", req[0], 1'b1);
        check("R10 wake with flag", wake[0], 1'b1);
        tick(); check("R10 wake one cycle", wake[0], 1'b0);
        tick(10); check("R6 flag held", req[0], 1'b1);

        // R7 poll reports and clears
        poll[0] = 1'b1; #1;
        check("R7 skip reports set", skip[0], 1'b1);
        tick();
        check("R7 flag cleared", req[0], 1'b0);
        check("R7 skip follows clear", skip[0], 1'b0);
        poll[0] = 1'b0;

        // R8 edge detected while a clearing poll happens
        pin[0] = 1'b0; tick(5);
        pin[0] = 1'b1; tick(3);              // flag set by this rise
        check("R8 setup flag", req[0], 1'b1);
        pin[0] = 1'b0; tick(5);
        pin[0] = 1'b1; tick(2);              // hit active before next edge
        poll[0] = 1'b1; #1;
        check("R8 skip during collision", skip[0], 1'b1);
        tick(); poll[0] = 1'b0;
        check("R8 flag kept", req[0], 1'b1);
        clear(0);

        // R9 write with identical values suppresses detection
        pin[0] = 1'b0; tick(5); clear(0); tick();
        pin[0] = 1'b1; tick();
        rise[0] = 1'b1; both[0] = 1'b0; we[0] = 1'b1;
        tick(); we[0] = 1'b0;
        tick(3);
        check("R9 detection muted", req[0], 1'b0);
        check("R9 no wake", wake[0], 1'b0);

        // R11 channel 1 works on its own, channel 0 quiet
        write_cfg(1, 1'b0, 1'b1);
        pin[1] = 1'b1; tick(3);
        check("R11 ch1 flag", req[1], 1'b1);
        check("R11 ch1 wake", wake[1], 1'b1);
        check("R11 ch0 unaffected", req[0], 1'b0);
        clear(1);
        check("R11 ch1 cleared", req[1], 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule